// File: doc/BRIEF.md
# Pattern Match and Change-of-State Interrupt Detector

This block raises a shared interrupt from two watchers on 8-bit input ports. The first compares port A, channel by channel, against a programmed pattern. Only the channels selected by a channel-enable mask take part in the comparison, and the rest are don't-care. The second watches port B and fires when any bit selected by its own enable mask toggles, in either direction.

Each watcher has an enable bit and a pending flag in the low nibble of a shared control byte. A flag is cleared by writing 1 to it. The interrupt output is high while either flag is pending.

Software programs the block through a simple synchronous write port and a registered read port. Any write to a register that shapes a watcher's decision re-arms that watcher's history, so a configuration write can never create an event by itself.

Top module: `pattern_change_irq`

## Requirements
- R1: After reset, all registers read 0, both flags are clear and `irq` is 0.
- R2: The registers sit at these byte offsets: control at 16, expected pattern at 20, match channel-enable at 24 and change channel-enable at 28. Control bit 0 is the match enable, bit 1 the match flag, bit 2 the change enable and bit 3 the change flag. Control bits 7:4 read 0. `rd_data` shows the register addressed by `rd_addr` one clock edge after `rd_addr` is sampled, and an unmapped address reads 0.
- R3: Port A matches when every channel whose channel-enable bit is 1 equals the corresponding pattern bit. Channels whose enable bit is 0 are ignored.
- R4: With match enabled, a transition of port A from not matching to matching sets the match flag and `irq` on the second rising edge after the new value is applied.
- R5: While port A stays matched, including through changes on ignored channels, a cleared match flag is not set again.
- R6: With change enabled, a change in either direction on any port B bit whose enable bit is 1 sets the change flag and `irq` on the second rising edge. Changes on bits whose enable bit is 0 are never reported.
- R7: Writing the control byte with bit 1 (or bit 3) at 1 clears the match (or change) flag, and writing 0 there leaves the flag unchanged. An event in the same cycle as the clear wins, and the flag stays set.
- R8: With a watcher's enable bit at 0, its flag never sets.
- R9: A write to the control byte or to a watcher's pattern or enable register re-arms that watcher. The conditions present at the write create no event, and later transitions are reported normally.
- R10: `irq` is registered and equals the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | 8 | Registered read data |
| port_a | input | 8 | Port watched by the pattern comparator |
| port_b | input | 8 | Port watched by the change detector |
| irq | output | 1 | Shared interrupt request, high while a flag is pending |

## Verification
Assertions check four behaviours on every cycle:
- `irq` follows the two flags.
- No flag rises while its enable bit was low.
- A clear write with no competing event leaves the flag low.
- An all-zero change mask never produces a change event.

The masked comparison and the changes on individual bits can only be shown by the bench. It sweeps full 256-value permutations of each port under several masks and patterns, and compares the results with an arithmetic model.

The bench's directed scenarios cover the rest:
- the two-edge latency;
- silence while a match persists;
- re-arming after a configuration write;
- an event winning over a clear in the same cycle.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int unsigned OFS_CTRL  = 16;
  localparam int unsigned OFS_PAT   = 20;
  localparam int unsigned OFS_PMASK = 24;
  localparam int unsigned OFS_CMASK = 28;

  localparam int CB_PM_EN  = 0;
  localparam int CB_PM_FLG = 1;
  localparam int CB_CS_EN  = 2;
  localparam int CB_CS_FLG = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PAT,
    SEL_PMASK,
    SEL_CMASK
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input int unsigned ofs);
    case (ofs)
      OFS_CTRL:  return SEL_CTRL;
      OFS_PAT:   return SEL_PAT;
      OFS_PMASK: return SEL_PMASK;
      OFS_CMASK: return SEL_CMASK;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pcirq_regs.sv
module pcirq_regs
  import pcirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pm_flag,
  input  logic              cs_flag,
  output logic              pm_en,
  output logic              cs_en,
  output logic [DATA_W-1:0] pattern,
  output logic [DATA_W-1:0] pm_mask,
  output logic [DATA_W-1:0] cs_mask,
  output logic              pm_rearm,
  output logic              cs_rearm,
  output logic              pm_clr,
  output logic              cs_clr
);
  localparam int PAD_W = 32 - ADDR_W;

  reg_sel_e wsel, rsel;
  logic     wr_ctrl;
  logic [DATA_W-1:0] ctrl_view;

  assign wsel    = decode_sel({{PAD_W{1'b0}}, wr_addr});
  assign rsel    = decode_sel({{PAD_W{1'b0}}, rd_addr});
  assign wr_ctrl = wr_en && (wsel == SEL_CTRL);

  assign pm_clr   = wr_ctrl && wr_data[CB_PM_FLG];
  assign cs_clr   = wr_ctrl && wr_data[CB_CS_FLG];
  assign pm_rearm = wr_en && (wsel == SEL_CTRL || wsel == SEL_PAT || wsel == SEL_PMASK);
  assign cs_rearm = wr_en && (wsel == SEL_CTRL || wsel == SEL_CMASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_en   <= 1'b0;
      cs_en   <= 1'b0;
      pattern <= '0;
      pm_mask <= '0;
      cs_mask <= '0;
    end else if (wr_en) begin
      case (wsel)
        SEL_CTRL: begin
          pm_en <= wr_data[CB_PM_EN];
          cs_en <= wr_data[CB_CS_EN];
        end
        SEL_PAT:   pattern <= wr_data;
        SEL_PMASK: pm_mask <= wr_data;
        SEL_CMASK: cs_mask <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_view            = '0;
    ctrl_view[CB_PM_EN]  = pm_en;
    ctrl_view[CB_PM_FLG] = pm_flag;
    ctrl_view[CB_CS_EN]  = cs_en;
    ctrl_view[CB_CS_FLG] = cs_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rsel)
        SEL_CTRL:  rd_data <= ctrl_view;
        SEL_PAT:   rd_data <= pattern;
        SEL_PMASK: rd_data <= pm_mask;
        SEL_CMASK: rd_data <= cs_mask;
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pcirq_match.sv
module pcirq_match #(
  parameter int DATA_W = 8,
  parameter int WARM_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] port_in,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] mask,
  input  logic              en,
  input  logic              rearm,
  input  logic              clr,
  output logic              flag,
  output logic              flag_nxt
);
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] miss;
  logic [WARM_N-1:0] warm;
  logic hit, hit_prev, ev;

  for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
    assign miss[i] = mask[i] & (a_q[i] ^ pattern[i]);
  end

  assign hit      = (miss == '0);
  assign ev       = en & warm[WARM_N-1] & hit & ~hit_prev;
  assign flag_nxt = ev | (flag & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      hit_prev <= 1'b0;
      warm     <= '0;
      flag     <= 1'b0;
    end else begin
      a_q      <= port_in;
      hit_prev <= hit;
      warm     <= rearm ? '0 : {warm[WARM_N-2:0], 1'b1};
      flag     <= flag_nxt;
    end
  end

  // R8
  pm_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(en));

  // R7
  pm_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !ev) |=> !flag);
endmodule

// File: rtl/pcirq_change.sv
module pcirq_change #(
  parameter int DATA_W = 8,
  parameter int WARM_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] port_in,
  input  logic [DATA_W-1:0] mask,
  input  logic              en,
  input  logic              rearm,
  input  logic              clr,
  output logic              flag,
  output logic              flag_nxt
);
  logic [DATA_W-1:0] b_q, b_prev, chg;
  logic [WARM_N-1:0] warm;
  logic ev;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign chg[i] = mask[i] & (b_q[i] ^ b_prev[i]);
  end

  assign ev       = en & warm[WARM_N-1] & (|chg);
  assign flag_nxt = ev | (flag & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q    <= '0;
      b_prev <= '0;
      warm   <= '0;
      flag   <= 1'b0;
    end else begin
      b_q    <= port_in;
      b_prev <= b_q;
      warm   <= rearm ? '0 : {warm[WARM_N-2:0], 1'b1};
      flag   <= flag_nxt;
    end
  end

  // R8
  cs_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(en));

  // R6
  cs_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(mask) != '0));

  // R7
  cs_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !ev) |=> !flag);
endmodule

// File: rtl/pattern_change_irq.sv
module pattern_change_irq #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] port_a,
  input  logic [DATA_W-1:0] port_b,
  output logic              irq
);
  localparam int WARM_N = 2;

  logic pm_en, cs_en, pm_rearm, cs_rearm, pm_clr, cs_clr;
  logic pm_flag, cs_flag, pm_nxt, cs_nxt;
  logic [DATA_W-1:0] pattern, pm_mask, cs_mask;

  pcirq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pm_flag(pm_flag), .cs_flag(cs_flag),
    .pm_en(pm_en), .cs_en(cs_en), .pattern(pattern), .pm_mask(pm_mask),
    .cs_mask(cs_mask), .pm_rearm(pm_rearm), .cs_rearm(cs_rearm),
    .pm_clr(pm_clr), .cs_clr(cs_clr)
  );

  pcirq_match #(.DATA_W(DATA_W), .WARM_N(WARM_N)) u_match (
    .clk(clk), .rst(rst), .port_in(port_a), .pattern(pattern), .mask(pm_mask),
    .en(pm_en), .rearm(pm_rearm), .clr(pm_clr), .flag(pm_flag), .flag_nxt(pm_nxt)
  );

  pcirq_change #(.DATA_W(DATA_W), .WARM_N(WARM_N)) u_change (
    .clk(clk), .rst(rst), .port_in(port_b), .mask(cs_mask),
    .en(cs_en), .rearm(cs_rearm), .clr(cs_clr), .flag(cs_flag), .flag_nxt(cs_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pm_nxt | cs_nxt;
  end

  // R10
  irq_follows_flags_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (pm_flag | cs_flag));
endmodule

// File: tb/tb_pattern_change_irq.sv
module tb_pattern_change_irq;
  localparam int CLK_P = 10;
  localparam logic [5:0] A_CTRL = 6'd16, A_PAT = 6'd20, A_PM = 6'd24, A_CM = 6'd28;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, port_a = 0, port_b = 0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  pattern_change_irq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .port_a(port_a), .port_b(port_b), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk); @(negedge clk); d = rd_data;
  endtask

  task automatic step_a(input logic [7:0] v);
    @(negedge clk); port_a = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step_b(input logic [7:0] v);
    @(negedge clk); port_b = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  // R3 R4 R5 R7 R8: sweep of port A against a masked pattern
  task automatic pm_sweep(input logic [7:0] msk, input logic [7:0] pat, input bit en, input int mult);
    logic prev, m, ef;
    logic [7:0] v;
    wr(A_PAT, pat); wr(A_PM, msk); wr(A_CTRL, {4'h0, 4'b1010} | {7'h0, en});
    prev = ((port_a ^ pat) & msk) == 0;
    ef = 0;
    for (int i = 0; i < 256; i++) begin
      v = 8'((i * mult + 3) & 255);
      step_a(v);
      m = ((v ^ pat) & msk) == 0;
      if (en && m && !prev) ef = 1;
      prev = m;
      chk(en ? "R3 R4 R5 match sweep" : "R8 match disabled", irq, ef);
      if (ef) begin
        wr(A_CTRL, {7'h0, en} | 8'h02);
        ef = 0;
        chk("R7 match clear", irq, 0);
      end
    end
  endtask

  // R6 R7 R8: sweep of port B against a change mask
  task automatic cs_sweep(input logic [7:0] msk, input bit en, input int mult);
    logic [7:0] prevb, v;
    logic ef;
    wr(A_CM, msk); wr(A_CTRL, 8'h0A | (en ? 8'h04 : 8'h00));
    prevb = port_b;
    ef = 0;
    for (int i = 0; i < 256; i++) begin
      v = 8'((i * mult + 7) & 255);
      step_b(v);
      if (en && (((v ^ prevb) & msk) != 0)) ef = 1;
      prevb = v;
      chk(en ? "R6 change sweep" : "R8 change disabled", irq, ef);
      if (ef) begin
        wr(A_CTRL, 8'h04 | 8'h08);
        ef = 0;
        chk("R7 change clear", irq, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
    rd(A_PAT, d);   chk("R1 pattern", d, 0);
    rd(A_PM, d);    chk("R1 match mask", d, 0);
    rd(A_CM, d);    chk("R1 change mask", d, 0);

    // R2 readback and layout
    wr(A_PAT, 8'hA5); wr(A_PM, 8'h3C); wr(A_CM, 8'h96); wr(A_CTRL, 8'hF5);
    rd(A_PAT, d);  chk("R2 pattern", d, 8'hA5);
    rd(A_PM, d);   chk("R2 match mask", d, 8'h3C);
    rd(A_CM, d);   chk("R2 change mask", d, 8'h96);
    rd(A_CTRL, d); chk("R2 ctrl upper bits zero", d, 8'h05);
    rd(6'd8, d);   chk("R2 unmapped", d, 8'h00);
    wr(A_CTRL, 8'h00);

    // R3 R4 worked example: mask C6, pattern 86
    wr(A_PAT, 8'h86); wr(A_PM, 8'hC6); wr(A_CTRL, 8'h01);
    @(negedge clk); port_a = 8'h87;
    @(posedge clk); @(negedge clk); chk("R4 not yet after first edge", irq, 0);
    @(posedge clk); @(negedge clk); chk("R4 set on second edge", irq, 1);
    rd(A_CTRL, d); chk("R2 match flag visible", d, 8'h03);
    wr(A_CTRL, 8'h03);
    rd(A_CTRL, d); chk("R7 match flag cleared", d, 8'h01);
    step_a(8'hBE); chk("R5 ignored channels, still matched", irq, 0);
    step_a(8'hC6); chk("R3 bit6 high breaks match", irq, 0);
    step_a(8'h86); chk("R3 rematch", irq, 1);
    wr(A_CTRL, 8'h03);

    // R9 config write does not create an event
    step_a(8'h00); chk("R9 pre", irq, 0);
    wr(A_PAT, 8'h00);
    chk("R9 pattern write quiet", irq, 0);
    rd(A_CTRL, d); chk("R9 flag clear", d, 8'h01);
    step_a(8'h40); chk("R9 unmatched", irq, 0);
    step_a(8'h00); chk("R9 armed after write", irq, 1);
    wr(A_CTRL, 8'h02);

    // R7 event wins over clear in same cycle
    wr(A_CM, 8'hFF); wr(A_CTRL, 8'h0C);
    @(negedge clk); port_b = ~port_b;
    @(posedge clk);
    @(negedge clk); wr_en = 1; wr_addr = A_CTRL; wr_data = 8'h0C;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
    chk("R7 set wins over clear", irq, 1);
    wr(A_CTRL, 8'h0C);
    chk("R7 clear after", irq, 0);
    rd(A_CTRL, d); chk("R7 ctrl after clear", d, 8'h04);

    // R10 both flags: irq stays while one remains
    wr(A_PAT, 8'h00); wr(A_PM, 8'h01); wr(A_CM, 8'h01); wr(A_CTRL, 8'h05);
    step_a(8'h01); step_a(8'h00);
    step_b(port_b ^ 8'h01);
    rd(A_CTRL, d); chk("R10 both flags", d, 8'h0F);
    wr(A_CTRL, 8'h07);
    chk("R10 irq held by change flag", irq, 1);
    wr(A_CTRL, 8'h0D);
    chk("R10 irq low", irq, 0);
    wr(A_CTRL, 8'h00);

    // sweeps
    pm_sweep(8'hC6, 8'h86, 1, 37);
    pm_sweep(8'hFF, 8'h5A, 1, 11);
    pm_sweep(8'h00, 8'h00, 1, 5);
    pm_sweep(8'h0F, 8'h03, 0, 29);
    wr(A_CTRL, 8'h02);
    cs_sweep(8'hFF, 1, 37);
    cs_sweep(8'h81, 1, 13);
    cs_sweep(8'h00, 1, 53);
    cs_sweep(8'hFF, 0, 19);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule